// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block behaves as an 8K x 8 non-volatile memory that answers on a two-wire serial bus. A fast system clock samples the bus clock and data lines. The block finds Start and Stop conditions in the sampled lines. It pulls the data line low through an open-drain enable. A master addresses the block with a control byte whose device bits are compared against three strap inputs. It then loads a 13-bit word address in two bytes. After that it either streams data bytes into a 32-byte page latch or reads bytes back through one shared address pointer.

A write is committed only when a Stop arrives. The latched bytes are copied into the array during a self-timed busy window, and the length of that window is a parameter counted in system clocks. While the window runs, the block does not acknowledge its control byte, so a master can poll for completion. A write-protect input shields the upper quarter of the array while leaving the rest writable.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the data line is released (sda_oe low), no commit is running, and the first addressed control byte is acknowledged.
- R2: A control byte is acknowledged only when its bits 7..4 are 1010 and its bits 3..1 equal strap_i[2:0]; bit 0 selects read (1) or write (0); bits go MSB first. A mismatching byte is not acknowledged and the block ignores the bus until the next Start.
- R3: sda_oe changes only while SCL is low; an acknowledge is given by holding SDA low through the ninth clock of a byte.
- R4: While wp_i is high, writes to addresses 0x1800..0x1FFF leave the array unchanged, and writes below 0x1800 still take effect; reads are unaffected by wp_i.
- R5: A write transfer carries a high address byte (only its low 5 bits are used) and then a low address byte; a write transfer that ends after the address bytes changes no data but sets the read pointer (random read).
- R6: A read returns the byte at the pointer and advances the pointer by one per byte sent; a master ACK requests the next byte, a NACK ends the read, and the pointer wraps from 0x1FFF to 0x0000.
- R7: Data bytes of a write fill a 32-byte page; the low 5 address bits wrap within the page, and afterwards the pointer holds the page address of the offset after the last data byte.
- R8: The commit starts only on a Stop that follows at least one complete data byte; for COMMIT_CYCLES clocks the control byte is not acknowledged, and afterwards the written bytes read back.
- R9: A Start at any point restarts control-byte reception; data bytes followed by a repeated Start instead of a Stop are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial bus clock as seen on the wire |
| sda_i | input | 1 | Serial bus data as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low (open-drain) |
| strap_i | input | 3 | Device select straps compared with control-byte bits 3..1 |
| wp_i | input | 1 | High protects the top quarter of the array |

## Verification
Directed transfers cover a matching, a wrong-strap and a wrong-prefix control byte, which separate address decode from the prefix check. They also cover a page write that crosses its page end, which shows in-page wrap as opposed to linear increment. A sequential read across 0x1FFF separates array wrap from page wrap. Protected and unprotected writes made with the protect input high show that only the top quarter is guarded. Polling the control byte right after a Stop, after an address-only write and after a repeated Start tells a running commit from no commit. Seeded random page writes of random length, random address and random protect level are then read back and compared with a bench model of the array and pointer.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RX,
    LS_RXACK,
    LS_TX,
    LS_TXACK
  } link_st_t;

  typedef enum logic [1:0] {
    RK_CTRL,
    RK_AHI,
    RK_ALO,
    RK_DATA
  } rx_kind_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/twi_bus_sampler.sv
module twi_bus_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [2:0] scl_q;
  logic [2:0] sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
  import twi_eeprom_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        strap_i,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              sda_low,
  output logic [ADDR_W-1:0] ptr,
  output logic              lat_we,
  output logic [PAGE_W-1:0] lat_off,
  output logic [7:0]        lat_din,
  output logic              base_set,
  output logic              lat_clear,
  output logic              commit_req
);
  localparam int HI_W = ADDR_W - 8;

  link_st_t        state;
  rx_kind_t        kind;
  logic [7:0]      shreg;
  logic [3:0]      bitcnt;
  logic [HI_W-1:0] addr_hi;
  logic            to_tx;
  logic            mack;
  logic            ctrl_hit;

  assign ctrl_hit = (shreg[7:4] == DEV_PREFIX) && (shreg[3:1] == strap_i) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LS_IDLE;
      kind       <= RK_CTRL;
      shreg      <= '0;
      bitcnt     <= '0;
      addr_hi    <= '0;
      to_tx      <= 1'b0;
      mack       <= 1'b0;
      sda_low    <= 1'b0;
      ptr        <= '0;
      lat_we     <= 1'b0;
      lat_off    <= '0;
      lat_din    <= '0;
      base_set   <= 1'b0;
      lat_clear  <= 1'b0;
      commit_req <= 1'b0;
    end else begin
      lat_we     <= 1'b0;
      base_set   <= 1'b0;
      lat_clear  <= 1'b0;
      commit_req <= 1'b0;
      if (start_det) begin
        state     <= LS_RX;
        kind      <= RK_CTRL;
        bitcnt    <= '0;
        sda_low   <= 1'b0;
        lat_clear <= 1'b1;
      end else if (stop_det) begin
        if (kind == RK_DATA && (state == LS_RX || state == LS_RXACK))
          commit_req <= 1'b1;
        state   <= LS_IDLE;
        sda_low <= 1'b0;
      end else begin
        case (state)
          LS_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt  <= '0;
              state   <= LS_RXACK;
              sda_low <= 1'b1;
              case (kind)
                RK_CTRL: begin
                  if (ctrl_hit) begin
                    to_tx <= shreg[0];
                    kind  <= RK_AHI;
                  end else begin
                    sda_low <= 1'b0;
                    state   <= LS_IDLE;
                  end
                end
                RK_AHI: begin
                  addr_hi <= shreg[HI_W-1:0];
                  kind    <= RK_ALO;
                end
                RK_ALO: begin
                  ptr      <= {addr_hi, shreg};
                  base_set <= 1'b1;
                  kind     <= RK_DATA;
                end
                default: begin
                  lat_we             <= 1'b1;
                  lat_off            <= ptr[PAGE_W-1:0];
                  lat_din            <= shreg;
                  ptr[PAGE_W-1:0]    <= ptr[PAGE_W-1:0] + 1'b1;
                end
              endcase
            end
          end
          LS_RXACK: begin
            if (scl_fall) begin
              if (to_tx) begin
                to_tx   <= 1'b0;
                shreg   <= rd_data;
                sda_low <= ~rd_data[7];
                bitcnt  <= '0;
                state   <= LS_TX;
              end else begin
                sda_low <= 1'b0;
                state   <= LS_RX;
              end
            end
          end
          LS_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_low <= 1'b0;
                ptr     <= ptr + 1'b1;
                state   <= LS_TXACK;
              end else begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_low <= ~shreg[6];
                bitcnt  <= bitcnt + 4'd1;
              end
            end
          end
          LS_TXACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                shreg   <= rd_data;
                sda_low <= ~rd_data[7];
                bitcnt  <= '0;
                state   <= LS_TX;
              end else begin
                state <= LS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_page_commit.sv
module twi_page_commit #(
  parameter int ADDR_W        = 13,
  parameter int PAGE_W        = 5,
  parameter int COMMIT_CYCLES = 50000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wp_i,
  input  logic                     lat_we,
  input  logic [PAGE_W-1:0]        lat_off,
  input  logic [7:0]               lat_din,
  input  logic                     base_set,
  input  logic [ADDR_W-PAGE_W-1:0] base_in,
  input  logic                     lat_clear,
  input  logic                     commit_req,
  output logic                     busy,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_din
);
  localparam int PAGE   = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] PAGE_C = CNT_W'(PAGE);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(COMMIT_CYCLES - 1);

  logic [7:0]        page_q [PAGE];
  logic [PAGE-1:0]   valid;
  logic [BASE_W-1:0] base;
  logic [CNT_W-1:0]  tcnt;
  logic [PAGE_W-1:0] idx;
  logic              guarded;

  assign idx     = tcnt[PAGE_W-1:0];
  assign guarded = wp_i && (base[BASE_W-1 -: 2] == 2'b11);

  generate
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!busy && lat_we && lat_off == PAGE_W'(g))
          page_q[g] <= lat_din;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= '0;
      base     <= '0;
      tcnt     <= '0;
      busy     <= 1'b0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_din  <= '0;
    end else begin
      mem_we <= 1'b0;
      if (busy) begin
        tcnt <= tcnt + 1'b1;
        if (tcnt < PAGE_C && valid[idx] && !guarded) begin
          mem_we   <= 1'b1;
          mem_addr <= {base, idx};
          mem_din  <= page_q[idx];
        end
        if (tcnt == LAST_C) begin
          busy  <= 1'b0;
          valid <= '0;
        end
      end else if (commit_req && |valid) begin
        busy <= 1'b1;
        tcnt <= '0;
      end else begin
        if (lat_clear || base_set)
          valid <= '0;
        if (base_set)
          base <= base_in;
        if (lat_we)
          valid[lat_off] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_array.sv
module twi_eeprom_array #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int ADDR_W        = 13,
  parameter int PAGE_W        = 5,
  parameter int COMMIT_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              busy;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] ptr;
  logic              lat_we;
  logic [PAGE_W-1:0] lat_off;
  logic [7:0]        lat_din;
  logic              base_set;
  logic              lat_clear;
  logic              commit_req;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_din;
  logic [BASE_W-1:0] base_in;

  assign base_in = ptr[ADDR_W-1:PAGE_W];

  twi_bus_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_link_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap_i(strap_i), .busy(busy), .rd_data(rd_data), .sda_low(sda_oe),
    .ptr(ptr), .lat_we(lat_we), .lat_off(lat_off), .lat_din(lat_din),
    .base_set(base_set), .lat_clear(lat_clear), .commit_req(commit_req)
  );

  twi_page_commit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .COMMIT_CYCLES(COMMIT_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .wp_i(wp_i), .lat_we(lat_we), .lat_off(lat_off),
    .lat_din(lat_din), .base_set(base_set), .base_in(base_in),
    .lat_clear(lat_clear), .commit_req(commit_req), .busy(busy),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_din(mem_din)
  );

  twi_eeprom_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_din),
    .raddr(ptr), .rdata(rd_data)
  );
endmodule

// File: rtl/twi_eeprom_checker.sv
module twi_eeprom_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       busy,
  input logic       mem_we,
  input logic [1:0] mem_top,
  input logic       wp_i,
  input logic       stop_det
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i); // R3

  AST_WRITE_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(busy)); // R8

  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det, 2)); // R8

  AST_GUARD_TOP_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(wp_i)) |-> (mem_top != 2'b11)); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9
endmodule

bind twi_eeprom_slave twi_eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
  .mem_we(mem_we), .mem_top(mem_addr[ADDR_W-1 -: 2]), .wp_i(wp_i),
  .stop_det(stop_det)
);

// File: tb/twi_eeprom_slave_tb_top.sv
module twi_eeprom_slave_tb_top;
  localparam int COMMIT = 400;
  localparam int Q = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m_low = 1'b0;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_bus;

  always #5 clk = ~clk;
  assign sda_bus = ~(sda_m_low | sda_oe);

  twi_eeprom_slave #(.ADDR_W(13), .PAGE_W(5), .COMMIT_CYCLES(COMMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [8192];
  bit ref_known [8192];
  int ref_ptr = 0;
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m_low = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m_low = 1'b1; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m_low = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m_low = 1'b0; wt(2 * Q);
  endtask

  task automatic send_bit(bit b);
    sda_m_low = ~b; wt(Q);
    scl_m = 1'b1; wt(2 * Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_bit(output bit b);
    sda_m_low = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_bus; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic send_byte(logic [7:0] d, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input bit give_ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  function automatic logic [7:0] ctrl(bit rw, logic [2:0] s);
    return {4'b1010, s, rw};
  endfunction

  function automatic int page_addr(int a, int i);
    return (a & 32'h1FE0) | ((a + i) & 32'h1F);
  endfunction

  task automatic model_write(int a, int n);
    for (int i = 0; i < n; i++) begin
      int t = page_addr(a, i);
      if (!(wp && t >= 32'h1800)) begin
        ref_mem[t] = wbuf[i];
        ref_known[t] = 1'b1;
      end
    end
    ref_ptr = (n > 0) ? page_addr(a, n) : a;
  endtask

  task automatic do_write(int a, int n, logic [2:0] hi_top, output bit ok);
    bit k;
    ok = 1'b1;
    bus_start();
    send_byte(ctrl(1'b0, STRAP), k); ok &= k;
    send_byte({hi_top, 5'(a >> 8)}, k); ok &= k;
    send_byte(8'(a), k); ok &= k;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], k);
      ok &= k;
    end
    bus_stop();
    model_write(a, n);
  endtask

  task automatic do_rread(int a, int n, output bit ok);
    bit k;
    ok = 1'b1;
    bus_start();
    send_byte(ctrl(1'b0, STRAP), k); ok &= k;
    send_byte({3'b000, 5'(a >> 8)}, k); ok &= k;
    send_byte(8'(a), k); ok &= k;
    bus_start();
    send_byte(ctrl(1'b1, STRAP), k); ok &= k;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bus_stop();
    ref_ptr = (a + n) & 32'h1FFF;
  endtask

  task automatic do_cread(int n, output bit ok);
    bit k;
    bus_start();
    send_byte(ctrl(1'b1, STRAP), k);
    ok = k;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
    bus_stop();
  endtask

  task automatic poll(output bit ack);
    bus_start();
    send_byte(ctrl(1'b0, STRAP), ack);
    bus_stop();
  endtask

  task automatic cmp_read(int a, int n, string tag);
    for (int i = 0; i < n; i++) begin
      int t = (a + i) & 32'h1FFF;
      if (ref_known[t]) chk(rbuf[i] === ref_mem[t], tag, int'(rbuf[i]), int'(ref_mem[t]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    bit k;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8192; i++) ref_known[i] = 1'b0;
    wt(5);
    rst_n = 1'b1;
    wt(5);

    // R1: released line and idle after reset
    chk(sda_oe == 1'b0, "R1 sda released", int'(sda_oe), 0);
    poll(k);
    chk(k, "R1 first control byte acked", int'(k), 1);

    // R2: wrong straps and wrong prefix are not acked
    bus_start();
    send_byte(ctrl(1'b0, 3'b100), k);
    bus_stop();
    chk(!k, "R2 strap mismatch", int'(k), 0);
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, k);
    bus_stop();
    chk(!k, "R2 prefix mismatch", int'(k), 0);

    // R8: commit window NACKs polling, then data reads back
    for (int i = 0; i < 5; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(32'h0010, 5, 3'b000, ok);
    chk(ok, "R7 page write acks", int'(ok), 1);
    poll(k);
    chk(!k, "R8 busy nack", int'(k), 0);
    wt(COMMIT + 20);
    poll(k);
    chk(k, "R8 ack after commit", int'(k), 1);

    // R5 R6: random read then current read continues
    do_rread(32'h0010, 4, ok);
    chk(ok, "R5 random read acks", int'(ok), 1);
    cmp_read(32'h0010, 4, "R6 sequential data");
    do_cread(1, ok);
    chk(rbuf[0] === 8'hA4, "R6 current read next", int'(rbuf[0]), 8'hA4);

    // R7: pointer after write stays in page
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(32'h0100, 3, 3'b000, ok);
    wt(COMMIT + 20);
    wbuf[0] = 8'h44; wbuf[1] = 8'h55;
    do_write(32'h0100, 2, 3'b000, ok);
    wt(COMMIT + 20);
    do_cread(1, ok);
    chk(rbuf[0] === 8'h33, "R7 pointer after write", int'(rbuf[0]), 8'h33);

    // R7: offset wraps inside the page; R5 upper hi bits ignored
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hC0 + 8'(i);
    do_write(32'h003E, 4, 3'b111, ok);
    wt(COMMIT + 20);
    do_rread(32'h0020, 2, ok);
    chk(rbuf[0] === 8'hC2 && rbuf[1] === 8'hC3, "R7 page wrap", int'({rbuf[0], rbuf[1]}), 16'hC2C3);
    do_rread(32'h003E, 2, ok);
    cmp_read(32'h003E, 2, "R5 high address bits");

    // R4: protection of the top quarter only
    wbuf[0] = 8'h5A;
    do_write(32'h1900, 1, 3'b000, ok);
    wt(COMMIT + 20);
    wp = 1'b1;
    wbuf[0] = 8'hE1;
    do_write(32'h1900, 1, 3'b000, ok);
    wt(COMMIT + 20);
    wbuf[0] = 8'h3C;
    do_write(32'h1000, 1, 3'b000, ok);
    wt(COMMIT + 20);
    do_rread(32'h1900, 1, ok);
    chk(rbuf[0] === 8'h5A, "R4 protected unchanged", int'(rbuf[0]), 8'h5A);
    do_rread(32'h1000, 1, ok);
    chk(rbuf[0] === 8'h3C, "R4 low area writable", int'(rbuf[0]), 8'h3C);
    wp = 1'b0;

    // R6: wrap at end of array
    wbuf[0] = 8'h7E;
    do_write(32'h1FFF, 1, 3'b000, ok);
    wt(COMMIT + 20);
    wbuf[0] = 8'h81;
    do_write(32'h0000, 1, 3'b000, ok);
    wt(COMMIT + 20);
    do_rread(32'h1FFF, 2, ok);
    chk(rbuf[0] === 8'h7E && rbuf[1] === 8'h81, "R6 array wrap", int'({rbuf[0], rbuf[1]}), 16'h7E81);

    // R8: address-only write starts no commit
    bus_start();
    send_byte(ctrl(1'b0, STRAP), k);
    send_byte(8'h00, k);
    send_byte(8'h10, k);
    bus_stop();
    poll(k);
    chk(k, "R8 no commit without data", int'(k), 1);

    // R9: repeated start discards latched data
    bus_start();
    send_byte(ctrl(1'b0, STRAP), k);
    send_byte(8'h00, k);
    send_byte(8'h10, k);
    send_byte(8'hEE, k);
    bus_start();
    send_byte(ctrl(1'b1, STRAP), k);
    chk(k, "R9 restart acked", int'(k), 1);
    recv_byte(rbuf[0], 1'b0);
    bus_stop();
    chk(rbuf[0] === 8'hA1, "R9 pointer after restart", int'(rbuf[0]), 8'hA1);
    do_rread(32'h0010, 1, ok);
    chk(rbuf[0] === 8'hA0, "R9 data discarded", int'(rbuf[0]), 8'hA0);

    // random page writes and read-back (R4 R6 R7)
    for (int it = 0; it < 10; it++) begin
      int a = int'($urandom % 8192);
      int n = 1 + int'($urandom % 16);
      wp = 1'($urandom);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(a, n, 3'($urandom), ok);
      chk(ok, "R7 random write acks", int'(ok), 1);
      wt(COMMIT + 20);
      wp = 1'b0;
      do_rread(a & 32'h1FE0, 32, ok);
      cmp_read(a & 32'h1FE0, 32, "R4 R7 random readback");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule